// File: doc/BRIEF.md
# SPI GPIO Expander Register Front-End

This block is the register side of a three-port, eight-bit-per-port GPIO expander. It is an SPI target in mode 0 with an active-low chip select. It turns each 24-bit frame into one register read or one register write. It holds the configuration registers that the pin drivers use: output level, direction, polarity, output type, pull enable, pull direction, bus holder, glitch filter and interrupt mask, one byte of each per port. It also holds a scratch byte, a read-only identity byte and a software reset command.

The SPI pins are sampled with the system clock through two-flop synchronisers, so SCK must run several times slower than `clk`. A frame is a header of two bytes followed by one data byte. The first byte is a direction flag and a feature code. The second byte is a port nibble, three reserved bits and a multi-port flag. The multi-port flag is captured and brought out as a pin; it does not change how the address is decoded. A write lands only when chip select rises after exactly 24 clocks. A read returns its byte on MISO during the third byte of the same frame.

Top module: `spi_gpio_regfront`

## Requirements
- R1: A frame is 24 bits sent MSB first, with MOSI sampled on rising SCK while `spiCsN` is low. Bit 23 = 1 makes the frame a read and 0 makes it a write. A write takes effect only after `spiCsN` rises.
- R2: Bits 22..16 are the feature code and bits 15..12 are the port number. Bits 11..9 must be zero. Bit 8 is the multi-port flag: it takes no part in decoding, and `multiPort` shows its value from the most recent header.
- R3: Feature 0x00 with port 0 is a scratch byte that can be read and written, and it resets to 0x00.
- R4: Feature 0x01 with port 0 reads 0x01, and writes to it change nothing.
- R5: Feature 0x02, ports 0 to 2, reads `pinIn` for that port XOR that port's polarity byte. Writes to it change nothing.
- R6: The per-port registers can be read and written at feature codes output 0x03, direction 0x04, polarity 0x05, open-drain 0x06, pull enable 0x08, pull-up select 0x09, bus holder 0x0A, mask 0x0C and glitch filter 0x0D. Each appears on its output port with port p at bits 8p+7..8p. Mask resets to 0xFF; every other register resets to 0x00.
- R7: A frame with a port number above 2, an unmapped feature code, a nonzero reserved bit, or a nonzero port on a single-byte register writes nothing and reads 0x00.
- R8: A frame in which `spiCsN` rises after any bit count other than 24 is discarded and writes nothing.
- R9: Writing feature 0x1A (port 0) with data bit 0 = 1 returns every writable register to its reset value and pulses `devResetPulse` high for exactly one `clk` cycle.
- R10: Writing feature 0x1A with data bits 1..0 = 2'b10 returns every writable register to its reset value with no pulse. Any other data value does nothing. A read of 0x1A returns 0x00, because the command clears itself.
- R11: During the third byte of a read, MISO shifts out the addressed byte MSB first, and each bit is valid before the rising SCK that samples it. At all other times, including while `spiCsN` is high, MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spiSck | input | 1 | SPI clock, mode 0 |
| spiCsN | input | 1 | SPI chip select, active low |
| spiMosi | input | 1 | SPI data from the controller |
| spiMiso | output | 1 | SPI data to the controller |
| pinIn | input | 24 | Sampled pin levels, port p at bits 8p+7..8p |
| outLevel | output | 24 | Output level bytes |
| dirOut | output | 24 | Direction bytes (1 = output) |
| polInv | output | 24 | Input polarity inversion bytes |
| openDrain | output | 24 | Output type bytes (1 = open drain) |
| pullEn | output | 24 | Pull resistor enable bytes |
| pullUp | output | 24 | Pull direction bytes (1 = up) |
| busHold | output | 24 | Bus holder enable bytes |
| irqMask | output | 24 | Interrupt mask bytes (1 = masked) |
| glitchEn | output | 24 | Glitch filter enable bytes |
| multiPort | output | 1 | Multi-port flag from the last header |
| devResetPulse | output | 1 | One-cycle device reset request |

## Verification
The bench cuts frames short and lets them run long. A design that commits on the 24th bit instead of on chip-select release, or that does not check the bit count, would then change an output byte. It writes to the input feature, to port 3, to an unmapped code and to an address with a reserved bit set. A design with a loose decoder would alias these writes onto real registers, and a loose read path would return nonzero data for them. It fires both software reset modes and also a data value that should do nothing. This catches a missing or stretched reset pulse, a mask that comes back as 0x00 instead of 0xFF, and a reset that a stray data bit can trigger. It also checks that MISO stays low during writes and outside frames, and that polarity folds into input reads.

// File: rtl/spi_gpio_pkg.sv
package spi_gpio_pkg;

  typedef enum logic [3:0] {
    CFG_OUT, CFG_DIR, CFG_POL, CFG_OTYPE, CFG_PEN,
    CFG_PSEL, CFG_HOLD, CFG_MASK, CFG_GLITCH
  } cfgSel_e;

  localparam int CFG_N = 9;

  localparam logic [6:0] FEAT_SCRATCH = 7'h00;
  localparam logic [6:0] FEAT_ID      = 7'h01;
  localparam logic [6:0] FEAT_INPUT   = 7'h02;
  localparam logic [6:0] FEAT_SWRST   = 7'h1A;

  // feature code of each per-port configuration register
  function automatic logic [6:0] cfgFeat(input int idx);
    case (idx)
      0:       return 7'h03;
      1:       return 7'h04;
      2:       return 7'h05;
      3:       return 7'h06;
      4:       return 7'h08;
      5:       return 7'h09;
      6:       return 7'h0A;
      7:       return 7'h0C;
      default: return 7'h0D;
    endcase
  endfunction

  typedef struct packed {
    logic       wrEn;
    logic [6:0] feat;
    logic [3:0] port;
    logic [2:0] rsvd;
    logic [7:0] data;
  } spiStrobe_t;

endpackage

// File: rtl/spi_gpio_ctrl.sv
module spi_gpio_ctrl
  import spi_gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spiSck,
  input  logic       spiCsN,
  input  logic       spiMosi,
  input  logic [7:0] rdData,
  output spiStrobe_t strobe,
  output logic       spiMiso,
  output logic       multiPort
);

  localparam int FRAME_BITS = 24;
  localparam int HDR_BITS   = 16;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);

  logic [2:0]            sckQ, csQ;
  logic [1:0]            mosiQ;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] shiftIn;
  logic [HDR_BITS-1:0]   hdr;
  logic                  loadRd, rdActive, wrPend;
  logic [7:0]            rdShift, wrData;

  logic sckRise, csHi, csRise, inBit;
  assign sckRise = sckQ[1] & ~sckQ[2];
  assign csHi    = csQ[1];
  assign csRise  = csQ[1] & ~csQ[2];
  assign inBit   = mosiQ[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckQ     <= '0;
      csQ      <= '1;
      mosiQ    <= '0;
      bitCnt   <= '0;
      shiftIn  <= '0;
      hdr      <= '0;
      loadRd   <= 1'b0;
      rdActive <= 1'b0;
      rdShift  <= '0;
      wrPend   <= 1'b0;
      wrData   <= '0;
    end else begin
      sckQ   <= {sckQ[1:0], spiSck};
      csQ    <= {csQ[1:0], spiCsN};
      mosiQ  <= {mosiQ[0], spiMosi};
      loadRd <= 1'b0;
      wrPend <= 1'b0;
      if (csHi) begin
        bitCnt   <= '0;
        rdActive <= 1'b0;
      end else if (sckRise) begin
        shiftIn <= {shiftIn[FRAME_BITS-2:0], inBit};
        if (bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(HDR_BITS - 1)) begin
          hdr    <= {shiftIn[HDR_BITS-2:0], inBit};
          loadRd <= 1'b1;
        end
        if (bitCnt >= CNT_W'(HDR_BITS) && bitCnt < CNT_W'(FRAME_BITS))
          rdShift <= {rdShift[6:0], 1'b0};
      end
      if (loadRd) begin
        rdActive <= hdr[HDR_BITS-1];
        rdShift  <= rdData;
      end
      if (csRise && bitCnt == CNT_W'(FRAME_BITS) && !shiftIn[FRAME_BITS-1]) begin
        wrPend <= 1'b1;
        wrData <= shiftIn[7:0];
      end
    end
  end

  always_comb begin
    strobe.wrEn = wrPend;
    strobe.feat = hdr[14:8];
    strobe.port = hdr[7:4];
    strobe.rsvd = hdr[3:1];
    strobe.data = wrData;
  end

  assign spiMiso   = rdActive & rdShift[7];
  assign multiPort = hdr[0];

  // R11: MISO stays low once chip select has been high for two samples
  a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (csQ[1] && csQ[2]) |-> !spiMiso);

  // R8: bit counter saturates and never wraps into a valid count
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_SAT);

  // R1: a write strobe only follows chip-select release
  a_r1_wr_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    wrPend |-> csQ[2]);

endmodule

// File: rtl/spi_gpio_regs.sv
module spi_gpio_regs
  import spi_gpio_pkg::*;
#(
  parameter int         NPORT  = 3,
  parameter logic [7:0] DEV_ID = 8'h01
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  spiStrobe_t                          strobe,
  input  logic [NPORT*8-1:0]                  pinIn,
  output logic [7:0]                          rdData,
  output logic [CFG_N-1:0][NPORT-1:0][7:0]    cfgOut,
  output logic                                devResetPulse
);

  localparam int HIT_N = CFG_N * NPORT;

  logic [CFG_N-1:0][NPORT-1:0][7:0] cfgQ;
  logic [HIT_N-1:0] wrHit;
  logic [7:0]       scratchQ;
  logic [1:0]       swRstQ;   // [0] device reset, [1] register reset
  logic             addrOk, singleOk, swRstHit, scratchHit;

  assign addrOk     = (strobe.rsvd == 3'b000);
  assign singleOk   = addrOk && (strobe.port == 4'd0);
  assign swRstHit   = strobe.wrEn && singleOk && (strobe.feat == FEAT_SWRST);
  assign scratchHit = strobe.wrEn && singleOk && (strobe.feat == FEAT_SCRATCH);

  for (genvar g = 0; g < CFG_N; g++) begin : g_cfg
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam logic [7:0] RST_VAL = (g == int'(CFG_MASK)) ? 8'hFF : 8'h00;
      assign wrHit[g*NPORT+p] = strobe.wrEn && addrOk &&
                                (strobe.feat == cfgFeat(g)) &&
                                (strobe.port == 4'(p));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cfgQ[g][p] <= RST_VAL;
        else if (swRstQ != 2'b00)   cfgQ[g][p] <= RST_VAL;
        else if (wrHit[g*NPORT+p])  cfgQ[g][p] <= strobe.data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratchQ <= '0;
      swRstQ   <= '0;
    end else begin
      if (swRstQ != 2'b00)  scratchQ <= '0;
      else if (scratchHit)  scratchQ <= strobe.data;
      if (swRstHit && strobe.data[0])      swRstQ <= 2'b01;
      else if (swRstHit && strobe.data[1]) swRstQ <= 2'b10;
      else                                 swRstQ <= 2'b00;
    end
  end

  assign devResetPulse = swRstQ[0];
  assign cfgOut        = cfgQ;

  always_comb begin
    rdData = 8'h00;
    if (singleOk && strobe.feat == FEAT_SCRATCH) rdData = scratchQ;
    if (singleOk && strobe.feat == FEAT_ID)      rdData = DEV_ID;
    for (int p = 0; p < NPORT; p++) begin
      if (addrOk && strobe.port == 4'(p)) begin
        if (strobe.feat == FEAT_INPUT)
          rdData = pinIn[p*8 +: 8] ^ cfgQ[CFG_POL][p];
        for (int g = 0; g < CFG_N; g++)
          if (strobe.feat == cfgFeat(g)) rdData = cfgQ[g][p];
      end
    end
  end

  // R7: one write lands on at most one configuration byte
  a_r7_onehot_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrHit));

  // R10: software reset command clears itself after one cycle
  a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (swRstQ != 2'b00) |=> (swRstQ == 2'b00));

  // R6: a software reset brings every mask byte back to all ones
  a_r6_mask_default: assert property (@(posedge clk) disable iff (!rst_n)
    (swRstQ != 2'b00) |=> (cfgQ[CFG_MASK] == {NPORT{8'hFF}}));

  // R9: device reset request is a single-cycle pulse
  a_r9_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    devResetPulse |=> !devResetPulse);

endmodule

// File: rtl/spi_gpio_regfront.sv
module spi_gpio_regfront
  import spi_gpio_pkg::*;
#(
  parameter int         NPORT  = 3,
  parameter logic [7:0] DEV_ID = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               spiSck,
  input  logic               spiCsN,
  input  logic               spiMosi,
  output logic               spiMiso,
  input  logic [NPORT*8-1:0] pinIn,
  output logic [NPORT*8-1:0] outLevel,
  output logic [NPORT*8-1:0] dirOut,
  output logic [NPORT*8-1:0] polInv,
  output logic [NPORT*8-1:0] openDrain,
  output logic [NPORT*8-1:0] pullEn,
  output logic [NPORT*8-1:0] pullUp,
  output logic [NPORT*8-1:0] busHold,
  output logic [NPORT*8-1:0] irqMask,
  output logic [NPORT*8-1:0] glitchEn,
  output logic               multiPort,
  output logic               devResetPulse
);

  spiStrobe_t                       strobe;
  logic [7:0]                       rdData;
  logic [CFG_N-1:0][NPORT-1:0][7:0] cfgOut;

  spi_gpio_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .spiSck    (spiSck),
    .spiCsN    (spiCsN),
    .spiMosi   (spiMosi),
    .rdData    (rdData),
    .strobe    (strobe),
    .spiMiso   (spiMiso),
    .multiPort (multiPort)
  );

  spi_gpio_regs #(.NPORT(NPORT), .DEV_ID(DEV_ID)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe        (strobe),
    .pinIn         (pinIn),
    .rdData        (rdData),
    .cfgOut        (cfgOut),
    .devResetPulse (devResetPulse)
  );

  assign outLevel  = cfgOut[CFG_OUT];
  assign dirOut    = cfgOut[CFG_DIR];
  assign polInv    = cfgOut[CFG_POL];
  assign openDrain = cfgOut[CFG_OTYPE];
  assign pullEn    = cfgOut[CFG_PEN];
  assign pullUp    = cfgOut[CFG_PSEL];
  assign busHold   = cfgOut[CFG_HOLD];
  assign irqMask   = cfgOut[CFG_MASK];
  assign glitchEn  = cfgOut[CFG_GLITCH];

endmodule

// File: tb/spi_gpio_regfront_bench.sv
`timescale 1ns/1ps
module spi_gpio_regfront_bench;

  localparam int HALF = 200;  // SPI half period in ns (10 clk cycles)

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spiSck = 1'b0, spiCsN = 1'b1, spiMosi = 1'b0;
  logic spiMiso;
  logic [23:0] pinIn = 24'h0;
  logic [23:0] outLevel, dirOut, polInv, openDrain, pullEn, pullUp, busHold, irqMask, glitchEn;
  logic multiPort, devResetPulse;

  int checks = 0, failures = 0, pulseCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  spi_gpio_regfront u_spi_gpio_regfront (
    .clk(clk), .rst_n(rst_n), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .pinIn(pinIn), .outLevel(outLevel), .dirOut(dirOut),
    .polInv(polInv), .openDrain(openDrain), .pullEn(pullEn), .pullUp(pullUp),
    .busHold(busHold), .irqMask(irqMask), .glitchEn(glitchEn),
    .multiPort(multiPort), .devResetPulse(devResetPulse)
  );

  always @(negedge clk) if (rst_n && devResetPulse) pulseCnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one frame; nbits other than 24 gives a short or long frame
  task automatic xfer(input logic rw, input logic [6:0] feat, input logic [3:0] port,
                      input logic [2:0] rsvd, input logic mp, input logic [7:0] data,
                      input int nbits, output logic [7:0] rd);
    logic [23:0] w;
    w = {rw, feat, port, rsvd, mp, data};
    rd = 8'h00;
    spiCsN = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      spiMosi = (i < 24) ? w[23-i] : 1'b0;
      #(HALF);
      if (i >= 16 && i < 24) rd = {rd[6:0], spiMiso};
      spiSck = 1'b1;
      #(HALF);
      spiSck = 1'b0;
    end
    #(HALF);
    spiCsN = 1'b1;
    #(3*HALF);
  endtask

  task automatic wr(input logic [6:0] feat, input logic [3:0] port, input logic [7:0] data);
    logic [7:0] d;
    xfer(1'b0, feat, port, 3'b000, 1'b0, data, 24, d);
    chk("R11 miso low in write", {24'h0, d}, 32'h0);
  endtask

  task automatic rdReg(input logic [6:0] feat, input logic [3:0] port, output logic [7:0] d);
    xfer(1'b1, feat, port, 3'b000, 1'b0, 8'h00, 24, d);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R6 reset mask", irqMask, 24'hFFFFFF);
    chk("R6 reset out", outLevel, 24'h0);
    chk("R6 reset dir", dirOut, 24'h0);
    chk("R11 miso idle", {31'h0, spiMiso}, 32'h0);
    rdReg(7'h00, 4'd0, d); chk("R3 scratch reset", d, 8'h00);
    rdReg(7'h0C, 4'd2, d); chk("R6 mask read port2", d, 8'hFF);
  endtask

  task automatic t_scratch_id;
    logic [7:0] d;
    wr(7'h00, 4'd0, 8'hA5);
    rdReg(7'h00, 4'd0, d); chk("R3 scratch rw", d, 8'hA5);
    rdReg(7'h01, 4'd0, d); chk("R4 id value", d, 8'h01);
    wr(7'h01, 4'd0, 8'h7E);
    rdReg(7'h01, 4'd0, d); chk("R4 id read-only", d, 8'h01);
    rdReg(7'h00, 4'd0, d); chk("R4 id write spares scratch", d, 8'hA5);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    wr(7'h03, 4'd0, 8'h12); wr(7'h03, 4'd1, 8'h34); wr(7'h03, 4'd2, 8'h56);
    chk("R6 out ports", outLevel, 24'h563412);
    wr(7'h04, 4'd1, 8'hF0); chk("R6 dir port1", dirOut, 24'h00F000);
    wr(7'h06, 4'd2, 8'h81); chk("R6 open drain", openDrain, 24'h810000);
    wr(7'h08, 4'd0, 8'h0F); chk("R6 pull en", pullEn, 24'h00000F);
    wr(7'h09, 4'd1, 8'h3C); chk("R6 pull up", pullUp, 24'h003C00);
    wr(7'h0A, 4'd2, 8'h99); chk("R6 bus hold", busHold, 24'h990000);
    wr(7'h0C, 4'd1, 8'h00); chk("R6 mask port1", irqMask, 24'hFF00FF);
    wr(7'h0D, 4'd0, 8'hC3); chk("R6 glitch", glitchEn, 24'h0000C3);
    rdReg(7'h03, 4'd1, d); chk("R11 read out port1", d, 8'h34);
    rdReg(7'h09, 4'd1, d); chk("R6 read pull up", d, 8'h3C);
  endtask

  task automatic t_input;
    logic [7:0] d;
    pinIn = 24'hC3_5A_81;
    wr(7'h05, 4'd1, 8'hFF);
    chk("R6 polarity", polInv, 24'h00FF00);
    rdReg(7'h02, 4'd0, d); chk("R5 input port0", d, 8'h81);
    rdReg(7'h02, 4'd1, d); chk("R5 input port1 inverted", d, 8'hA5);
    rdReg(7'h02, 4'd2, d); chk("R5 input port2", d, 8'hC3);
    wr(7'h02, 4'd0, 8'h00);
    rdReg(7'h02, 4'd0, d); chk("R5 input write ignored", d, 8'h81);
    chk("R5 input write spares out", outLevel, 24'h563412);
    wr(7'h05, 4'd1, 8'h00);
  endtask

  task automatic t_unmapped;
    logic [7:0] d;
    wr(7'h03, 4'd3, 8'hEE); chk("R7 port3 write", outLevel, 24'h563412);
    rdReg(7'h03, 4'd3, d); chk("R7 port3 read", d, 8'h00);
    wr(7'h07, 4'd0, 8'hEE); rdReg(7'h07, 4'd0, d); chk("R7 unmapped read", d, 8'h00);
    xfer(1'b0, 7'h03, 4'd0, 3'b010, 1'b0, 8'hEE, 24, d);
    chk("R7 reserved bits write", outLevel, 24'h563412);
    xfer(1'b1, 7'h03, 4'd0, 3'b001, 1'b0, 8'h00, 24, d);
    chk("R7 reserved bits read", d, 8'h00);
    wr(7'h00, 4'd1, 8'h11); rdReg(7'h00, 4'd0, d); chk("R7 scratch port1", d, 8'hA5);
    rdReg(7'h1A, 4'd0, d); chk("R10 swrst reads zero", d, 8'h00);
  endtask

  task automatic t_frames;
    logic [7:0] d;
    xfer(1'b0, 7'h03, 4'd0, 3'b000, 1'b0, 8'hEE, 20, d);
    chk("R8 short frame", outLevel, 24'h563412);
    xfer(1'b0, 7'h03, 4'd0, 3'b000, 1'b0, 8'hEE, 25, d);
    chk("R8 long frame", outLevel, 24'h563412);
    xfer(1'b0, 7'h03, 4'd1, 3'b000, 1'b1, 8'h77, 24, d);
    chk("R2 multiport flag", {31'h0, multiPort}, 32'h1);
    chk("R2 multiport write", outLevel, 24'h567712);
    wr(7'h03, 4'd1, 8'h34);
    chk("R2 multiport cleared", {31'h0, multiPort}, 32'h0);
    chk("R1 full frame write", outLevel, 24'h563412);
  endtask

  task automatic t_swreset;
    logic [7:0] d;
    int p0;
    p0 = pulseCnt;
    wr(7'h1A, 4'd0, 8'h04);
    chk("R10 other data ignored", outLevel, 24'h563412);
    chk("R10 no pulse on other data", pulseCnt, p0);
    wr(7'h1A, 4'd0, 8'h02);
    chk("R10 register reset out", outLevel, 24'h0);
    chk("R10 register reset mask", irqMask, 24'hFFFFFF);
    chk("R10 no pulse", pulseCnt, p0);
    rdReg(7'h00, 4'd0, d); chk("R10 scratch cleared", d, 8'h00);
    wr(7'h04, 4'd2, 8'h5A); wr(7'h00, 4'd0, 8'h3C); wr(7'h0C, 4'd0, 8'h00);
    chk("R9 setup dir", dirOut, 24'h5A0000);
    wr(7'h1A, 4'd0, 8'h01);
    chk("R9 device reset pulse", pulseCnt, p0 + 1);
    chk("R9 device reset dir", dirOut, 24'h0);
    chk("R9 device reset mask", irqMask, 24'hFFFFFF);
    rdReg(7'h00, 4'd0, d); chk("R9 scratch cleared", d, 8'h00);
    rdReg(7'h1A, 4'd0, d); chk("R10 self-cleared", d, 8'h00);
    chk("R11 miso idle end", {31'h0, spiMiso}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #3 rst_n = 1'b1;
    #(2*HALF);
    t_reset();
    t_scratch_id();
    t_cfg();
    t_input();
    t_unmapped();
    t_frames();
    t_swreset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule